// File: doc/BRIEF.md
# Sequencing Serial ADC Controller

This block runs an eight-input, 10-bit serial analogue-to-digital converter over a four-wire link: an active-low select, a serial clock, a command line out to the converter and a data line back from it. It is built from a frame shifter and a sequencer. The shifter moves one 16-bit full-duplex frame each time the sequencer asks for one, and it reports the end of that frame. The sequencer brings the converter up after reset and sets it to step through its inputs on its own. From then on it only reads results.

After reset the sequencer sends two frames of all ones so the converter can leave its own reset state. It then sends one control frame. That frame selects automatic stepping from input 0 up to a chosen last input, and it picks the input range. The range and last-input selections are taken only at that moment. Every later frame carries an all-zero command. Each reply carries a channel tag and a 10-bit value. The value is written to that channel's output register. A one-cycle set-valid pulse marks the storing of the last channel in the sequence.

Top module: `adc_seq_ctrl`

## Requirements
- R1: While reset is held, `adc_cs_n` and `adc_sclk` are 1, `set_valid` is 0 and all result registers are 0.
- R2: The first two frames after reset carry 16'hFFFF on `adc_mosi`.
- R3: The third frame is the control word, laid out as follows: bit 15 = 1 (write), bits 14..12 = `last_ch`, bits 11..10 = 2'b11 (automatic stepping), bit 9 = `range_sel`, bits 8..0 = 0.
- R4: Every frame after the control frame carries 16'h0000 on `adc_mosi`.
- R5: A frame holds `adc_cs_n` low for exactly 16 rising edges of `adc_sclk`, and `adc_sclk` idles high. `adc_mosi` is sent MSB first and changes only while `adc_sclk` is low. Both data lines are sampled on the rising edge.
- R6: One `adc_sclk` period lasts `CLK_DIV` system clocks (8 by default): half low, half high.
- R7: Data returned during the two wake frames and the control frame is discarded, so all results stay 0.
- R8: In a reply frame, bits 14..12 give the channel and bits 11..2 give the value. The value is stored at `results[ch*10 +: 10]`. No other channel changes.
- R9: `set_valid` is a one-cycle pulse. It is issued when, and only when, a result tagged with the configured last channel is stored.
- R10: `range_sel` and `last_ch` are used only for the control frame. Changing them later sends no new control frame and does not move the set-valid point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| range_sel | input | 1 | Input range bit placed in the control frame |
| last_ch | input | 3 | Last channel of the automatic sequence |
| adc_miso | input | 1 | Serial data from the converter |
| adc_cs_n | output | 1 | Active-low frame select |
| adc_sclk | output | 1 | Serial clock, idles high |
| adc_mosi | output | 1 | Serial command data to the converter |
| results | output | 80 | Eight 10-bit results, channel n at bits n*10+9..n*10 |
| set_valid | output | 1 | One-cycle pulse when a full sequence has been stored |

## Verification
The bench uses a converter model that decodes the received control word and then returns replies tagged with their channel. In most of them the value grows with each pass. A reply frame with the last channel set to 0 makes every frame complete a set. A design that compared against the wrong channel would then miss pulses, or pulse on the wrong reply. Each wake and control frame gets back a reply tagged with channel 7. A design that stored data before the run phase would show non-zero results straight after configuration. The select inputs are changed in the middle of a run. A design that read them live would move the set-valid point or send a second control frame. Sending the bits LSB first, or changing the data line while the clock is high, breaks the captured wake and control words.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int FRAME_W  = 16;
  localparam int CH_W     = 3;
  localparam int NUM_CH   = 1 << CH_W;
  localparam int RES_W    = 10;
  // reply field positions
  localparam int TAG_LSB  = 12;
  localparam int VAL_LSB  = 2;
  // control word field positions
  localparam int WR_BIT   = 15;
  localparam int LAST_LSB = 12;
  localparam int MODE_LSB = 10;
  localparam int RNG_BIT  = 9;

  typedef enum logic [1:0] {PH_WAKE, PH_CFG, PH_RUN} phase_t;

  function automatic logic [FRAME_W-1:0] make_ctrl(input logic rng, input logic [CH_W-1:0] last);
    logic [FRAME_W-1:0] w;
    w = '0;
    w[WR_BIT] = 1'b1;
    w[LAST_LSB +: CH_W] = last;
    w[MODE_LSB +: 2] = 2'b11;
    w[RNG_BIT] = rng;
    return w;
  endfunction
endpackage

// File: rtl/adc_seq_shifter.sv
module adc_seq_shifter
  import adc_seq_pkg::*;
#(
  parameter int CLK_DIV = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               go,
  input  logic [FRAME_W-1:0] tx_word,
  input  logic               miso,
  output logic               cs_n,
  output logic               sclk,
  output logic               mosi,
  output logic               done,
  output logic [FRAME_W-1:0] rx_word
);
  localparam int HALF = CLK_DIV / 2;
  localparam int DCW  = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam int BCW  = $clog2(FRAME_W);

  logic               busy;
  logic [DCW-1:0]     dcnt;
  logic [BCW-1:0]     bcnt;
  logic [FRAME_W-1:0] tx_sh;
  logic [FRAME_W-1:0] rx_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      cs_n    <= 1'b1;
      sclk    <= 1'b1;
      mosi    <= 1'b0;
      done    <= 1'b0;
      dcnt    <= '0;
      bcnt    <= '0;
      tx_sh   <= '0;
      rx_sh   <= '0;
      rx_word <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (go) begin
          busy  <= 1'b1;
          cs_n  <= 1'b0;
          sclk  <= 1'b0;
          mosi  <= tx_word[FRAME_W-1];
          tx_sh <= tx_word << 1;
          dcnt  <= DCW'(1);
          bcnt  <= '0;
        end
      end else begin
        dcnt <= dcnt + 1'b1;
        if (dcnt == '0) begin
          sclk  <= 1'b0;
          mosi  <= tx_sh[FRAME_W-1];
          tx_sh <= tx_sh << 1;
        end
        if (dcnt == DCW'(HALF)) begin
          sclk  <= 1'b1;
          rx_sh <= {rx_sh[FRAME_W-2:0], miso};
        end
        if (dcnt == DCW'(CLK_DIV-1)) begin
          dcnt <= '0;
          if (bcnt == BCW'(FRAME_W-1)) begin
            busy    <= 1'b0;
            cs_n    <= 1'b1;
            done    <= 1'b1;
            rx_word <= rx_sh;
          end else begin
            bcnt <= bcnt + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/adc_seq_master.sv
module adc_seq_master
  import adc_seq_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               range_sel,
  input  logic [CH_W-1:0]    last_ch,
  input  logic               done,
  input  logic [FRAME_W-1:0] rx_word,
  output logic               go,
  output logic [FRAME_W-1:0] tx_word,
  output logic               wr_en,
  output logic [CH_W-1:0]    wr_ch,
  output logic [RES_W-1:0]   wr_val,
  output logic               set_valid
);
  phase_t          phase;
  logic            wake_idx;
  logic            in_flight;
  logic [CH_W-1:0] last_q;

  assign wr_ch  = rx_word[TAG_LSB +: CH_W];
  assign wr_val = rx_word[VAL_LSB +: RES_W];
  assign wr_en  = in_flight && done && (phase == PH_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_WAKE;
      wake_idx  <= 1'b0;
      in_flight <= 1'b0;
      go        <= 1'b0;
      tx_word   <= '0;
      last_q    <= '0;
      set_valid <= 1'b0;
    end else begin
      go        <= 1'b0;
      set_valid <= 1'b0;
      if (!in_flight) begin
        go        <= 1'b1;
        in_flight <= 1'b1;
        case (phase)
          PH_WAKE: tx_word <= '1;
          PH_CFG: begin
            tx_word <= make_ctrl(range_sel, last_ch);
            last_q  <= last_ch;
          end
          default: tx_word <= '0;
        endcase
      end else if (done) begin
        in_flight <= 1'b0;
        case (phase)
          PH_WAKE: begin
            wake_idx <= ~wake_idx;
            if (wake_idx) phase <= PH_CFG;
          end
          PH_CFG:  phase <= PH_RUN;
          default: if (wr_ch == last_q) set_valid <= 1'b1;
        endcase
      end
    end
  end
endmodule

// File: rtl/adc_seq_bank.sv
module adc_seq_bank
  import adc_seq_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [CH_W-1:0]         wr_ch,
  input  logic [RES_W-1:0]        wr_val,
  output logic [NUM_CH*RES_W-1:0] results
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst)
        results[i*RES_W +: RES_W] <= '0;
      else if (wr_en && (wr_ch == CH_W'(i)))
        results[i*RES_W +: RES_W] <= wr_val;
    end
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int CLK_DIV = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    range_sel,
  input  logic [CH_W-1:0]         last_ch,
  input  logic                    adc_miso,
  output logic                    adc_cs_n,
  output logic                    adc_sclk,
  output logic                    adc_mosi,
  output logic [NUM_CH*RES_W-1:0] results,
  output logic                    set_valid
);
  logic               go;
  logic               done;
  logic [FRAME_W-1:0] tx_word;
  logic [FRAME_W-1:0] rx_word;
  logic               wr_en;
  logic [CH_W-1:0]    wr_ch;
  logic [RES_W-1:0]   wr_val;

  adc_seq_master u_master (
    .clk(clk), .rst(rst), .range_sel(range_sel), .last_ch(last_ch),
    .done(done), .rx_word(rx_word), .go(go), .tx_word(tx_word),
    .wr_en(wr_en), .wr_ch(wr_ch), .wr_val(wr_val), .set_valid(set_valid)
  );

  adc_seq_shifter #(.CLK_DIV(CLK_DIV)) u_shift (
    .clk(clk), .rst(rst), .go(go), .tx_word(tx_word), .miso(adc_miso),
    .cs_n(adc_cs_n), .sclk(adc_sclk), .mosi(adc_mosi),
    .done(done), .rx_word(rx_word)
  );

  adc_seq_bank u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_ch(wr_ch), .wr_val(wr_val),
    .results(results)
  );
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
  parameter int HALF = 4
) (
  input logic clk,
  input logic rst,
  input logic adc_cs_n,
  input logic adc_sclk,
  input logic adc_mosi,
  input logic set_valid
);
  logic [15:0] lo_cnt;

  always_ff @(posedge clk) begin
    if (rst)            lo_cnt <= '0;
    else if (!adc_sclk) lo_cnt <= lo_cnt + 1'b1;
    else                lo_cnt <= '0;
  end

  AST_SCLK_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst) adc_cs_n |-> adc_sclk); // R5
  AST_CS_MOVES_WITH_SCLK_HIGH: assert property (@(posedge clk) disable iff (rst) !adc_sclk |-> !adc_cs_n); // R5
  AST_MOSI_STEADY_AT_RISE: assert property (@(posedge clk) disable iff (rst) $rose(adc_sclk) |-> $stable(adc_mosi)); // R5
  AST_SCLK_LOW_HALF: assert property (@(posedge clk) disable iff (rst) $rose(adc_sclk) |-> (lo_cnt == 16'(HALF))); // R6
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) set_valid |=> !set_valid); // R9
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.HALF(CLK_DIV/2)) u_chk (
  .clk(clk), .rst(rst), .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk),
  .adc_mosi(adc_mosi), .set_valid(set_valid)
);

// File: tb/adc_seq_ctrl_tb.sv
`timescale 1ns/1ps
module adc_seq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        range_sel = 1'b0;
  logic [2:0]  last_ch = 3'd0;
  logic        adc_miso;
  logic        adc_cs_n, adc_sclk, adc_mosi, set_valid;
  logic [79:0] results;

  always #5 clk = ~clk;

  adc_seq_ctrl u_dut (
    .clk(clk), .rst(rst), .range_sel(range_sel), .last_ch(last_ch),
    .adc_miso(adc_miso), .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk),
    .adc_mosi(adc_mosi), .results(results), .set_valid(set_valid)
  );

  int n_checks = 0;
  int n_errors = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string req, input string what);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: %s", req, what);
    end
  endtask

  // ---------------- converter model ----------------
  int          fidx, bit_i, prog_last, last_ret_ch, sclk_bad, mosi_nz, last_rise;
  logic [15:0] ret_word, cap;
  logic [9:0]  exp_res [8];
  logic        cfg_rng;
  logic [2:0]  cfg_last;

  assign adc_miso = (bit_i < 16) ? ret_word[15 - bit_i] : 1'b0;

  always @(negedge clk) cyc++;

  always @(negedge adc_cs_n) begin
    if (!rst) begin
      bit_i = 0;
      cap   = '0;
      if (fidx < 3) ret_word = 16'h7ABC;
      else begin
        int k, ch, ps;
        k  = fidx - 3;
        ch = k % (prog_last + 1);
        ps = k / (prog_last + 1);
        ret_word = {1'b0, 3'(ch), 10'((ps * 37 + ch * 5 + 1) & 1023), 2'b00};
      end
    end
  end

  always @(posedge adc_sclk) begin
    if (!rst && !adc_cs_n) begin
      if (bit_i > 0 && (cyc - last_rise) != 8) sclk_bad++;
      last_rise = cyc;
      cap = {cap[14:0], adc_mosi};
      bit_i++;
    end
  end

  always @(posedge adc_cs_n) begin
    if (!rst) begin
      chk(bit_i == 16, "R5", $sformatf("frame %0d rising edges act=%0d exp=16", fidx, bit_i));
      if (fidx < 2)
        chk(cap == 16'hFFFF, "R2", $sformatf("wake frame %0d act=%h exp=ffff", fidx, cap));
      else if (fidx == 2) begin
        logic [15:0] e;
        e = {1'b1, cfg_last, 2'b11, cfg_rng, 9'd0};
        chk(cap == e, "R3", $sformatf("control word act=%h exp=%h", cap, e));
        prog_last = int'(cap[14:12]);
      end else begin
        if (cap != 16'h0000) mosi_nz++;
        exp_res[ret_word[14:12]] = ret_word[11:2];
        last_ret_ch = int'(ret_word[14:12]);
      end
      fidx++;
      bit_i = 16;
    end
  end

  // ---------------- set-valid monitor ----------------
  int sv_count;
  logic sv_prev;
  always @(negedge clk) begin
    if (rst) sv_prev = 1'b0;
    else begin
      if (set_valid) begin
        sv_count++;
        chk(!sv_prev, "R9", "set_valid high two cycles act=1 exp=0");
        chk(last_ret_ch == prog_last, "R9",
            $sformatf("pulse after channel act=%0d exp=%0d", last_ret_ch, prog_last));
        for (int c = 0; c < 8; c++)
          chk(results[c*10 +: 10] == exp_res[c], "R8",
              $sformatf("ch%0d act=%h exp=%h", c, results[c*10 +: 10], exp_res[c]));
      end
      sv_prev = set_valid;
    end
  end

  // ---------------- helpers ----------------
  task automatic start_run(input logic rng, input logic [2:0] last);
    @(negedge clk);
    rst = 1'b1;
    range_sel = rng; last_ch = last;
    cfg_rng = rng; cfg_last = last;
    repeat (3) @(negedge clk);
    chk(adc_cs_n && adc_sclk && !set_valid && results == '0, "R1",
        $sformatf("reset cs_n=%b sclk=%b sv=%b res=%h exp 1 1 0 0", adc_cs_n, adc_sclk, set_valid, results));
    fidx = 0; bit_i = 16; prog_last = 7; last_ret_ch = -1; sclk_bad = 0; mosi_nz = 0;
    sv_count = 0; ret_word = '0;
    for (int c = 0; c < 8; c++) exp_res[c] = '0;
    rst = 1'b0;
    // wait until the control frame has finished, then check nothing was stored
    while (fidx < 3) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(results == '0, "R7", $sformatf("results after setup act=%h exp=0", results));
  endtask

  task automatic wait_sets(input int n, input string req);
    int guard = 0;
    while (sv_count < n && guard < 30000) begin
      @(negedge clk);
      guard++;
    end
    chk(sv_count >= n, req, $sformatf("set_valid pulses act=%0d exp=%0d", sv_count, n));
  endtask

  // vector: {range, last, passes}
  localparam logic [7:0] VECS [5] = '{
    {1'b0, 3'd7, 4'd2},
    {1'b1, 3'd3, 4'd3},
    {1'b0, 3'd5, 4'd2},
    {1'b1, 3'd0, 4'd5},
    {1'b1, 3'd6, 4'd1}
  };

  initial begin
    fidx = 0; bit_i = 16; ret_word = '0; sv_count = 0; cfg_rng = 0; cfg_last = 0;
    for (int v = 0; v < 5; v++) begin
      start_run(VECS[v][7], VECS[v][6:4]);
      wait_sets(int'(VECS[v][3:0]), "R9");
      chk(sclk_bad == 0, "R6", $sformatf("sclk period errors act=%0d exp=0", sclk_bad));
      chk(mosi_nz == 0, "R4", $sformatf("non-zero run frames act=%0d exp=0", mosi_nz));
    end
    // R10: selections changed mid-run have no effect
    start_run(1'b1, 3'd2);
    wait_sets(1, "R10");
    @(negedge clk);
    range_sel = 1'b0; last_ch = 3'd6;
    wait_sets(4, "R10");
    chk(mosi_nz == 0, "R10", $sformatf("new control frames act=%0d exp=0", mosi_nz));
    chk(results[79:30] == '0, "R10", $sformatf("channels 3..7 act=%h exp=0", results[79:30]));
    chk(prog_last == 2, "R10", $sformatf("programmed last act=%0d exp=2", prog_last));
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #1_500_000;
    n_checks++; n_errors++;
    $display("FAIL watchdog: run hung act=timeout exp=finish");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule